// File: doc/BRIEF.md
# Machine-Mode CSR Access Unit

This block executes the register-access operations of an RV32 core that has only machine and user privilege. Each request carries the operation code, a 12-bit register address, the destination and source register indices, the source value and the current privilege. In the same cycle the block returns the old register value, reports whether a real read and a real write take place, and raises an illegal-instruction flag when the access breaks the rules. The register file is updated on the next clock edge.

Legality is decided from the address alone. The top two address bits mark the read-only quadrant, and the next two give the minimum privilege. Writes to a zero destination suppress the read, and a set or clear whose source index is zero suppresses the write. Every implemented register applies its own write-any/read-legal coercion, so `wr_data` is always the value that a later read returns. The trap sequence that consumes `illegal` belongs to the core. The core must also record cause code 2 and the offending instruction bits.

Requests arrive on `req_valid`. The unit is always ready, so it has no back-pressure: the core may present one request every cycle, and every result is valid only in the cycle of its request.

Top module: `csr_unit`

## Requirements
- R1: The low two bits of `req_funct3` select the operation: 01 write, 10 set bits (OR), 11 clear bits (AND NOT). Bit 2 set selects the zero-extended 5-bit `req_rs1` index as the source instead of `req_rs1_val`. The codes 000 and 100 are illegal.
- R2: When address bits [11:10] are 11 and the request performs a real write, `illegal` is raised at every privilege level.
- R3: When `req_priv` is 00 (user) and address bits [9:8] are 11, `illegal` is raised, even for a pure read.
- R4: A write operation (low bits 01) with `req_rd` = 0 gives `rd_valid` = 0 and `rd_data` = 0, and the write still happens.
- R5: A set or clear with `req_rs1` = 0 gives `wr_strobe` = 0. It raises no read-only illegal, so reading the hart ID at 0xF14 is legal.
- R6: An unimplemented address raises `illegal`. An illegal request never asserts `wr_strobe` and leaves every register unchanged.
- R7: mtvec (0x305) keeps BASE in bits [31:2]. A MODE of 0 or 1 in bits [1:0] is stored as written, and MODE 2 or 3 is stored as 0.
- R8: mstatus (0x300) stores only MIE (bit 3), MPIE (bit 7) and MPP (bits [12:11]). An MPP value of 01 or 10 is stored as 00. All other bits read zero.
- R9: mepc (0x341) bit 0 always reads zero. misa (0x301) reads 0x40001104 and ignores writes.
- R10: mie (0x304) stores only bits 3, 7 and 11.
- R11: mip (0x344) reads `irq_pend[0]`, `irq_pend[1]` and `irq_pend[2]` at bits 3, 7 and 11. A write to mip is accepted but changes nothing.
- R12: `rd_data` is the value before the modification, and the new value can be read in the next cycle.
- R13: After reset, every writable register reads zero. The ID registers at 0xF11 to 0xF14 return their parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_funct3 | input | 3 | Operation code |
| req_addr | input | 12 | CSR address |
| req_rd | input | 5 | Destination register index |
| req_rs1 | input | 5 | Source register index or immediate |
| req_rs1_val | input | 32 | Source register value |
| req_priv | input | 2 | Current privilege, 11 machine, 00 user |
| irq_pend | input | 3 | Pending software, timer and external interrupts |
| rd_data | output | 32 | Old CSR value for the destination |
| rd_valid | output | 1 | A real read took place |
| wr_strobe | output | 1 | A real write takes place at the next edge |
| wr_data | output | 32 | Coerced value being written |
| illegal | output | 1 | Illegal-instruction condition |

## Verification
The assertions assume that `req_priv` only takes the values 00 and 11, and that the request fields are stable and known while `req_valid` is high. The bench drives every request on the falling edge, holds it for a full cycle, and uses only those two privilege codes. It returns `req_valid` low between requests, so every check depends on one request alone.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam logic [11:0] ADR_MSTATUS  = 12'h300;
  localparam logic [11:0] ADR_MISA     = 12'h301;
  localparam logic [11:0] ADR_MIE      = 12'h304;
  localparam logic [11:0] ADR_MTVEC    = 12'h305;
  localparam logic [11:0] ADR_MCNTEN   = 12'h306;
  localparam logic [11:0] ADR_MSCRATCH = 12'h340;
  localparam logic [11:0] ADR_MEPC     = 12'h341;
  localparam logic [11:0] ADR_MCAUSE   = 12'h342;
  localparam logic [11:0] ADR_MTVAL    = 12'h343;
  localparam logic [11:0] ADR_MIP      = 12'h344;
  localparam logic [11:0] ADR_VENDOR   = 12'hF11;
  localparam logic [11:0] ADR_ARCH     = 12'hF12;
  localparam logic [11:0] ADR_IMPL     = 12'hF13;
  localparam logic [11:0] ADR_HART     = 12'hF14;

  localparam int BIT_MIE    = 3;
  localparam int BIT_MPIE   = 7;
  localparam int BIT_MPP_LO = 11;
  localparam int NUM_IRQ    = 3;
  localparam int IRQ_BITS [NUM_IRQ] = '{3, 7, 11};
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
(
  input  logic        valid,
  input  logic [2:0]  funct3,
  input  logic [11:0] addr,
  input  logic [4:0]  rd,
  input  logic [4:0]  rs1,
  input  logic [1:0]  priv,
  input  logic        addr_hit,
  output csr_op_e     op,
  output logic        do_read,
  output logic        do_write,
  output logic        bad
);
  logic wants_write, wants_read, ro_space, priv_low, op_bad;

  always_comb begin
    op          = csr_op_e'(funct3[1:0]);
    op_bad      = (op == OP_NONE);
    wants_write = (op == OP_WRITE) || (rs1 != 5'd0);
    wants_read  = !((op == OP_WRITE) && (rd == 5'd0));
    ro_space    = (addr[11:10] == 2'b11);
    priv_low    = (priv < addr[9:8]);
    bad         = valid && (op_bad || !addr_hit || priv_low || (ro_space && wants_write));
    do_read     = valid && !bad && wants_read;
    do_write    = valid && !bad && wants_write;
  end
endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e          op,
  input  logic [XLEN-1:0]  old_val,
  input  logic [XLEN-1:0]  src,
  output logic [XLEN-1:0]  result
);
  always_comb begin
    unique case (op)
      OP_WRITE: result = src;
      OP_SET:   result = old_val | src;
      OP_CLEAR: result = old_val & ~src;
      default:  result = old_val;
    endcase
  end
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] VENDOR_ID = 32'h0,
  parameter logic [31:0] ARCH_ID   = 32'h0,
  parameter logic [31:0] IMPL_ID   = 32'h0,
  parameter logic [31:0] HART_ID   = 32'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [11:0]         addr,
  input  logic                we,
  input  logic [XLEN-1:0]     raw,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  output logic [XLEN-1:0]     cur,
  output logic                hit,
  output logic [XLEN-1:0]     legal
);
  localparam logic [XLEN-1:0] MISA_VAL =
    (XLEN'(1) << (XLEN-2)) | (XLEN'(1) << 12) | (XLEN'(1) << 8) | (XLEN'(1) << 2);
  localparam logic [XLEN-1:0] CNTEN_MASK = XLEN'(7);

  logic [XLEN-1:0] irq_mask, mip_view;
  logic [XLEN-1:0] mstatus_q, mie_q, mtvec_q, mcnten_q, mscratch_q, mepc_q, mcause_q, mtval_q;

  always_comb begin
    irq_mask = '0;
    mip_view = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      irq_mask[IRQ_BITS[i]] = 1'b1;
      mip_view[IRQ_BITS[i]] = irq_pend[i];
    end
  end

  always_comb begin
    hit = 1'b1;
    unique case (addr)
      ADR_MSTATUS:  cur = mstatus_q;
      ADR_MISA:     cur = MISA_VAL;
      ADR_MIE:      cur = mie_q;
      ADR_MTVEC:    cur = mtvec_q;
      ADR_MCNTEN:   cur = mcnten_q;
      ADR_MSCRATCH: cur = mscratch_q;
      ADR_MEPC:     cur = mepc_q;
      ADR_MCAUSE:   cur = mcause_q;
      ADR_MTVAL:    cur = mtval_q;
      ADR_MIP:      cur = mip_view;
      ADR_VENDOR:   cur = XLEN'(VENDOR_ID);
      ADR_ARCH:     cur = XLEN'(ARCH_ID);
      ADR_IMPL:     cur = XLEN'(IMPL_ID);
      ADR_HART:     cur = XLEN'(HART_ID);
      default: begin
        cur = '0;
        hit = 1'b0;
      end
    endcase
  end

  // Per-register write coercion: legal is exactly what a later read returns.
  always_comb begin
    legal = raw;
    unique case (addr)
      ADR_MSTATUS: begin
        legal = '0;
        legal[BIT_MIE]  = raw[BIT_MIE];
        legal[BIT_MPIE] = raw[BIT_MPIE];
        legal[BIT_MPP_LO+1:BIT_MPP_LO] =
          (raw[BIT_MPP_LO+1:BIT_MPP_LO] == 2'b11) ? 2'b11 : 2'b00;
      end
      ADR_MIE:    legal = raw & irq_mask;
      ADR_MTVEC:  legal = {raw[XLEN-1:2], 1'b0, raw[0] & ~raw[1]};
      ADR_MCNTEN: legal = raw & CNTEN_MASK;
      ADR_MEPC:   legal = {raw[XLEN-1:1], 1'b0};
      ADR_MISA, ADR_MIP, ADR_VENDOR, ADR_ARCH, ADR_IMPL, ADR_HART: legal = cur;
      default:    legal = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstatus_q  <= '0;
      mie_q      <= '0;
      mtvec_q    <= '0;
      mcnten_q   <= '0;
      mscratch_q <= '0;
      mepc_q     <= '0;
      mcause_q   <= '0;
      mtval_q    <= '0;
    end else if (we) begin
      unique case (addr)
        ADR_MSTATUS:  mstatus_q  <= legal;
        ADR_MIE:      mie_q      <= legal;
        ADR_MTVEC:    mtvec_q    <= legal;
        ADR_MCNTEN:   mcnten_q   <= legal;
        ADR_MSCRATCH: mscratch_q <= legal;
        ADR_MEPC:     mepc_q     <= legal;
        ADR_MCAUSE:   mcause_q   <= legal;
        ADR_MTVAL:    mtval_q    <= legal;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] VENDOR_ID = 32'h0,
  parameter logic [31:0] ARCH_ID   = 32'h0,
  parameter logic [31:0] IMPL_ID   = 32'h0,
  parameter logic [31:0] HART_ID   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_funct3,
  input  logic [11:0]       req_addr,
  input  logic [4:0]        req_rd,
  input  logic [4:0]        req_rs1,
  input  logic [XLEN-1:0]   req_rs1_val,
  input  logic [1:0]        req_priv,
  input  logic [2:0]        irq_pend,
  output logic [XLEN-1:0]   rd_data,
  output logic              rd_valid,
  output logic              wr_strobe,
  output logic [XLEN-1:0]   wr_data,
  output logic              illegal
);
  csr_op_e         op;
  logic            hit, do_read, do_write;
  logic [XLEN-1:0] src, cur, raw, legal;

  assign src = req_funct3[2] ? XLEN'(req_rs1) : req_rs1_val;

  csr_decode u_dec (
    .valid(req_valid), .funct3(req_funct3), .addr(req_addr), .rd(req_rd),
    .rs1(req_rs1), .priv(req_priv), .addr_hit(hit), .op(op),
    .do_read(do_read), .do_write(do_write), .bad(illegal)
  );

  csr_alu #(.XLEN(XLEN)) u_alu (.op(op), .old_val(cur), .src(src), .result(raw));

  csr_regs #(
    .XLEN(XLEN), .VENDOR_ID(VENDOR_ID), .ARCH_ID(ARCH_ID),
    .IMPL_ID(IMPL_ID), .HART_ID(HART_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .we(do_write), .raw(raw),
    .irq_pend(irq_pend), .cur(cur), .hit(hit), .legal(legal)
  );

  assign rd_valid  = do_read;
  assign rd_data   = do_read ? cur : '0;
  assign wr_strobe = do_write;
  assign wr_data   = do_write ? legal : '0;
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_funct3,
  input logic [11:0] req_addr,
  input logic [4:0]  req_rd,
  input logic [4:0]  req_rs1,
  input logic [1:0]  req_priv,
  input logic        rd_valid,
  input logic        wr_strobe,
  input logic [1:0]  wr_low,
  input logic        illegal
);
  // R2
  p_ro_write_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:10] == 2'b11 && (req_funct3[1:0] == 2'b01 || req_rs1 != 5'd0))
      |-> illegal);
  // R3
  p_user_machine_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'b00 && req_addr[9:8] == 2'b11) |-> illegal);
  // R4
  p_no_read_to_x0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_funct3[1:0] == 2'b01 && req_rd == 5'd0) |-> !rd_valid);
  // R5
  p_zero_src_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_funct3[1:0] != 2'b01 && req_rs1 == 5'd0) |-> !wr_strobe);
  // R6
  p_illegal_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_strobe && !rd_valid);
  // R7
  p_mtvec_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && req_addr == 12'h305) |-> !wr_low[1]);
  // R9
  p_mepc_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && req_addr == 12'h341) |-> !wr_low[0]);
endmodule

bind csr_unit csr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_funct3(req_funct3),
  .req_addr(req_addr), .req_rd(req_rd), .req_rs1(req_rs1), .req_priv(req_priv),
  .rd_valid(rd_valid), .wr_strobe(wr_strobe), .wr_low(wr_data[1:0]), .illegal(illegal)
);

// File: tb/csr_unit_tb.sv
module csr_unit_tb;
  localparam logic [31:0] HART = 32'd3;
  localparam logic [31:0] VEND = 32'h0000_0A5C;
  localparam logic [1:0]  PM = 2'b11;
  localparam logic [1:0]  PU = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_funct3 = '0;
  logic [11:0] req_addr = '0;
  logic [4:0] req_rd = '0, req_rs1 = '0;
  logic [31:0] req_rs1_val = '0;
  logic [1:0] req_priv = PM;
  logic [2:0] irq_pend = '0;
  logic [31:0] rd_data, wr_data;
  logic rd_valid, wr_strobe, illegal;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] s_rd, s_wd;
  logic s_rv, s_ws, s_il;

  always #2 clk = ~clk;

  csr_unit #(.VENDOR_ID(VEND), .HART_ID(HART)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_funct3(req_funct3),
    .req_addr(req_addr), .req_rd(req_rd), .req_rs1(req_rs1), .req_rs1_val(req_rs1_val),
    .req_priv(req_priv), .irq_pend(irq_pend), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .illegal(illegal)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] f3, logic [11:0] a, logic [4:0] rd, logic [4:0] rs1,
                       logic [31:0] v, logic [1:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_funct3 = f3; req_addr = a; req_rd = rd;
    req_rs1 = rs1; req_rs1_val = v; req_priv = p;
    #1;
    s_rd = rd_data; s_rv = rd_valid; s_ws = wr_strobe; s_wd = wr_data; s_il = illegal;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic peek(logic [11:0] a, output logic [31:0] v);
    issue(3'b010, a, 5'd1, 5'd0, 32'h0, PM);
    v = s_rd;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(12'h300, v); check("R13 mstatus reset", v, 32'h0);
    peek(12'h340, v); check("R13 mscratch reset", v, 32'h0);
    peek(12'hF11, v); check("R13 vendor id", v, VEND);
  endtask

  task automatic t_ops();
    logic [31:0] v;
    issue(3'b001, 12'h340, 5'd2, 5'd7, 32'hA5A5_0F0F, PM);
    check("R12 old value on write", s_rd, 32'h0);
    check("R1 write strobe", {31'b0, s_ws}, 32'h1);
    peek(12'h340, v); check("R12 written value visible", v, 32'hA5A5_0F0F);
    issue(3'b010, 12'h340, 5'd2, 5'd7, 32'h00F0_0000, PM);
    check("R12 old value on set", s_rd, 32'hA5A5_0F0F);
    peek(12'h340, v); check("R1 set bits", v, 32'hA5F5_0F0F);
    issue(3'b011, 12'h340, 5'd2, 5'd7, 32'hA500_0000, PM);
    peek(12'h340, v); check("R1 clear bits", v, 32'h00F5_0F0F);
    issue(3'b101, 12'h340, 5'd2, 5'h1F, 32'hFFFF_FFFF, PM);
    peek(12'h340, v); check("R1 immediate write", v, 32'h0000_001F);
    issue(3'b111, 12'h340, 5'd2, 5'h05, 32'hFFFF_FFFF, PM);
    peek(12'h340, v); check("R1 immediate clear", v, 32'h0000_001A);
    issue(3'b110, 12'h340, 5'd2, 5'h01, 32'h0, PM);
    peek(12'h340, v); check("R1 immediate set", v, 32'h0000_001B);
    issue(3'b000, 12'h340, 5'd2, 5'd7, 32'hFFFF_FFFF, PM);
    check("R1 funct3 000 illegal", {31'b0, s_il}, 32'h1);
  endtask

  task automatic t_legality();
    logic [31:0] v;
    issue(3'b001, 12'hF14, 5'd2, 5'd7, 32'h1234, PM);
    check("R2 write read-only illegal", {31'b0, s_il}, 32'h1);
    issue(3'b110, 12'hF14, 5'd2, 5'd4, 32'h0, PM);
    check("R2 immediate set read-only illegal", {31'b0, s_il}, 32'h1);
    issue(3'b010, 12'hF14, 5'd2, 5'd0, 32'h0, PM);
    check("R5 hart id read legal", {31'b0, s_il}, 32'h0);
    check("R5 hart id value", s_rd, HART);
    check("R5 no write strobe", {31'b0, s_ws}, 32'h0);
    issue(3'b010, 12'h300, 5'd2, 5'd0, 32'h0, PU);
    check("R3 user read of machine CSR illegal", {31'b0, s_il}, 32'h1);
    issue(3'b001, 12'h340, 5'd2, 5'd7, 32'hDEAD_BEEF, PU);
    check("R3 user write illegal", {31'b0, s_il}, 32'h1);
    check("R6 illegal has no strobe", {31'b0, s_ws}, 32'h0);
    peek(12'h340, v); check("R6 mscratch unchanged after illegal", v, 32'h0000_001B);
    issue(3'b001, 12'h7C0, 5'd2, 5'd7, 32'h1, PM);
    check("R6 unimplemented address illegal", {31'b0, s_il}, 32'h1);
    issue(3'b010, 12'h100, 5'd2, 5'd0, 32'h0, PM);
    check("R6 supervisor address illegal", {31'b0, s_il}, 32'h1);
    issue(3'b001, 12'h340, 5'd0, 5'd7, 32'h0000_5555, PM);
    check("R4 no read for rd x0", {31'b0, s_rv}, 32'h0);
    check("R4 rd data zero", s_rd, 32'h0);
    peek(12'h340, v); check("R4 write still done", v, 32'h0000_5555);
  endtask

  task automatic t_warl();
    logic [31:0] v;
    issue(3'b001, 12'h305, 5'd0, 5'd7, 32'h8000_1002, PM);
    peek(12'h305, v); check("R7 reserved mode coerced", v, 32'h8000_1000);
    issue(3'b001, 12'h305, 5'd0, 5'd7, 32'h8000_1001, PM);
    peek(12'h305, v); check("R7 vectored mode kept", v, 32'h8000_1001);
    issue(3'b001, 12'h300, 5'd0, 5'd7, 32'hFFFF_FFFF, PM);
    peek(12'h300, v); check("R8 mstatus mask", v, 32'h0000_1888);
    issue(3'b001, 12'h300, 5'd0, 5'd7, 32'h0000_0800, PM);
    peek(12'h300, v); check("R8 illegal MPP coerced", v, 32'h0);
    issue(3'b001, 12'h341, 5'd0, 5'd7, 32'hFFFF_FFFF, PM);
    peek(12'h341, v); check("R9 mepc bit0 zero", v, 32'hFFFF_FFFE);
    issue(3'b001, 12'h301, 5'd0, 5'd7, 32'h0, PM);
    peek(12'h301, v); check("R9 misa fixed", v, 32'h4000_1104);
    issue(3'b001, 12'h304, 5'd0, 5'd7, 32'hFFFF_FFFF, PM);
    peek(12'h304, v); check("R10 mie mask", v, 32'h0000_0888);
    irq_pend = 3'b101;
    peek(12'h344, v); check("R11 mip reflects inputs", v, 32'h0000_0808);
    issue(3'b011, 12'h344, 5'd0, 5'd7, 32'hFFFF_FFFF, PM);
    check("R11 mip write accepted", {31'b0, s_il}, 32'h0);
    peek(12'h344, v); check("R11 mip unchanged by write", v, 32'h0000_0808);
    irq_pend = 3'b000;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ops();
    t_legality();
    t_warl();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule